// File: doc/BRIEF.md
# Multichannel TDM Serial Framer

This block moves fixed-length words over a time-division multiplexed serial link. It has a transmit half and a receive half that share one slot sequencer. A frame sync marks the start of each frame. After a programmable gap of serial clocks, a programmable number of 16-bit slots follows back to back. The transmit half shifts each slot's word out MSB first. The receive half assembles each slot's word from the data pin and presents it with its slot index.

The serial bit rate comes from a one-cycle `bit_en` strobe in the system clock domain, so clock generation stays outside the block. Separate transmit and receive slot masks choose which slots the block drives and which it captures. The transmit pin is released (output enable low) in every slot it does not drive. Slot count, gap and masks are sampled on the frame-sync tick and held for the whole frame.

Alignment is exact on every frame, including the first frame after enable. There is no extra gap cycle, no bit slip and no dropped final slot for any gap value.

Top module: `tdm_framer`

## Requirements
- R1: While reset is asserted, `tdat`, `toe`, `rx_valid` and `frame_err` are 0 and `tx_chan` is 0.
- R2: A frame sync seen on bit tick k with gap D (`cfg_delay`, 0..3) puts bit 0 of slot 0 on bit tick k+1+D. `toe` rises on the clock edge of that tick. This holds on the first frame after `en` rises, with no added cycle.
- R3: An enabled transmit slot s drives the word presented on `tx_word` while `tx_chan` equals s. Its 16 bits go out MSB first on consecutive bit ticks, with no shift between slots.
- R4: An enabled receive slot captures `rdat` on each of its 16 bit ticks, first bit as MSB. On the clock after its last bit tick, `rx_valid` pulses for one cycle with the word on `rx_word` and the slot index on `rx_chan`. For example, 0x8000 in slot 1 and 0xA5A5 in slot 2 arrive unchanged.
- R5: A frame carries exactly `cfg_chan_last`+1 slots, for 1 up to 32, and the last slot is always sent and received. After the last bit, `toe` is low and no `rx_valid` occurs until the next frame sync.
- R6: During a slot whose bit in `cfg_tx_mask` is 0, `toe` and `tdat` are 0.
- R7: A slot whose bit in `cfg_rx_mask` is 0 produces no `rx_valid`.
- R8: A frame sync on a bit tick while a frame is still in its gap or slots sets `frame_err` for one cycle and restarts the frame. A sync on the very tick that carries the frame's final bit is a clean back-to-back frame: no error, and the final word is kept.
- R9: Slot count, gap and both masks are sampled only on the frame-sync tick. Changing them mid-frame has no effect on that frame.
- R10: With `en` low, `toe` and `tdat` are 0 on the next clock, any frame in progress is abandoned, and frame syncs are ignored with no capture and no error.
- R11: On clocks without `bit_en`, the sequencer, `tdat` and `toe` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Framer enable |
| bit_en | input | 1 | One-cycle strobe marking a serial bit tick |
| fsync | input | 1 | Frame sync, sampled on bit ticks |
| cfg_chan_last | input | 5 | Slots per frame minus one |
| cfg_delay | input | 2 | Bit ticks between the sync tick and the tick before slot 0 bit 0 |
| cfg_tx_mask | input | 32 | Per-slot transmit enable |
| cfg_rx_mask | input | 32 | Per-slot receive enable |
| tx_chan | output | 5 | Slot whose word is taken from `tx_word` |
| tx_word | input | 16 | Transmit word for slot `tx_chan` |
| tdat | output | 1 | Serial transmit data |
| toe | output | 1 | Transmit output enable |
| rdat | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-cycle pulse: received word ready |
| rx_chan | output | 5 | Slot index of the received word |
| rx_word | output | 16 | Received word |
| frame_err | output | 1 | One-cycle pulse: sync arrived before frame completion |

## Verification
The critical coincidence is a frame sync landing on the same bit tick as the previous frame's final data bit. On that tick, completion of the old frame and start of the new one fall in a single cycle. The bench provokes it by raising `fsync` on the last bit tick of a frame, then running the new frame's gap and slots. The case passes when the final word of the old frame is still captured, no error pulse appears, and the new frame keeps exact slot timing. A sync placed a few ticks earlier is the contrasting case, and it must raise the error.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_GAP  = 2'd1,
    PH_DATA = 2'd2
  } tdm_phase_e;

endpackage

// File: rtl/tdm_seq.sv
module tdm_seq
  import tdm_pkg::*;
#(
  parameter int MAX_CH = 32,
  parameter int WORD_W = 16,
  parameter int DLY_W  = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                en,
  input  logic                                bit_en,
  input  logic                                fsync,
  input  logic [((MAX_CH > 1) ? $clog2(MAX_CH) : 1)-1:0] cfg_chan_last,
  input  logic [DLY_W-1:0]                    cfg_delay,
  input  logic [MAX_CH-1:0]                   cfg_tx_mask,
  input  logic [MAX_CH-1:0]                   cfg_rx_mask,
  output logic                                data_tick,
  output logic                                first_bit,
  output logic                                last_bit,
  output logic                                tx_on,
  output logic                                rx_on,
  output logic [((MAX_CH > 1) ? $clog2(MAX_CH) : 1)-1:0] slot,
  output logic                                frame_err
);

  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  tdm_phase_e        phase_q, phase_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [CH_W-1:0]   slot_q, slot_d;
  logic [CH_W-1:0]   last_q, last_d;
  logic [MAX_CH-1:0] txm_q, txm_d;
  logic [MAX_CH-1:0] rxm_q, rxm_d;
  logic              err_q, err_d;

  logic word_end;
  logic frame_end;

  assign data_tick = en & bit_en & (phase_q == PH_DATA);
  assign word_end  = (bit_q == BIT_LAST);
  assign frame_end = data_tick & word_end & (slot_q == last_q);

  // next-state process
  always_comb begin
    phase_d = phase_q;
    dly_d   = dly_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    last_d  = last_q;
    txm_d   = txm_q;
    rxm_d   = rxm_q;
    err_d   = 1'b0;
    if (!en) begin
      phase_d = PH_IDLE;
      dly_d   = '0;
      bit_d   = '0;
      slot_d  = '0;
    end else if (bit_en) begin
      case (phase_q)
        PH_GAP: begin
          if (dly_q <= DLY_W'(1)) phase_d = PH_DATA;
          else                    dly_d   = dly_q - 1'b1;
        end
        PH_DATA: begin
          if (word_end) begin
            bit_d = '0;
            if (slot_q == last_q) begin
              phase_d = PH_IDLE;
              slot_d  = '0;
            end else begin
              slot_d = slot_q + 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
        default: ;
      endcase
      if (fsync) begin
        err_d   = (phase_q != PH_IDLE) && !frame_end;
        phase_d = (cfg_delay == '0) ? PH_DATA : PH_GAP;
        dly_d   = cfg_delay;
        bit_d   = '0;
        slot_d  = '0;
        last_d  = cfg_chan_last;
        txm_d   = cfg_tx_mask;
        rxm_d   = cfg_rx_mask;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      dly_q   <= '0;
      bit_q   <= '0;
      slot_q  <= '0;
      last_q  <= '0;
      txm_q   <= '0;
      rxm_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      dly_q   <= dly_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      last_q  <= last_d;
      txm_q   <= txm_d;
      rxm_q   <= rxm_d;
      err_q   <= err_d;
    end
  end

  assign first_bit = (bit_q == '0);
  assign last_bit  = word_end;
  assign tx_on     = txm_q[slot_q];
  assign rx_on     = rxm_q[slot_q];
  assign slot      = slot_q;
  assign frame_err = err_q;

  // R8: an error pulse only ever follows an accepted sync tick
  p_err_after_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(en && bit_en && fsync));

  // R5: the slot index never passes the frame's last slot
  p_slot_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |-> (slot_q <= last_q));

  // R11: no bit tick, no sequencer movement
  p_hold_between_ticks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bit_en) |=> ($stable(slot_q) && $stable(bit_q) && $stable(phase_q)));

endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic              data_tick,
  input  logic              first_bit,
  input  logic              tx_on,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tdat,
  output logic              toe
);

  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic            tdat_q, tdat_d;
  logic            toe_q, toe_d;

  // next-state process
  always_comb begin
    sh_d   = sh_q;
    tdat_d = tdat_q;
    toe_d  = toe_q;
    if (!en) begin
      tdat_d = 1'b0;
      toe_d  = 1'b0;
    end else if (bit_en) begin
      if (data_tick && tx_on) begin
        toe_d = 1'b1;
        if (first_bit) begin
          tdat_d = tx_word[WORD_W-1];
          sh_d   = tx_word[SH_W-1:0];
        end else begin
          tdat_d = sh_q[SH_W-1];
          sh_d   = {sh_q[SH_W-2:0], 1'b0};
        end
      end else begin
        tdat_d = 1'b0;
        toe_d  = 1'b0;
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      tdat_q <= 1'b0;
      toe_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tdat_q <= tdat_d;
      toe_q  <= toe_d;
    end
  end

  assign tdat = tdat_q;
  assign toe  = toe_q;

  // R10: disabling the framer silences the pin on the next clock
  p_quiet_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!toe && !tdat));

endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int WORD_W = 16,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_tick,
  input  logic              last_bit,
  input  logic              rx_on,
  input  logic [CH_W-1:0]   slot,
  input  logic              rdat,
  output logic              rx_valid,
  output logic [CH_W-1:0]   rx_chan,
  output logic [WORD_W-1:0] rx_word
);

  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              vld_q, vld_d;

  // next-state process
  always_comb begin
    sh_d   = sh_q;
    word_d = word_q;
    chan_d = chan_q;
    vld_d  = 1'b0;
    if (data_tick && rx_on) begin
      if (last_bit) begin
        word_d = {sh_q, rdat};
        chan_d = slot;
        vld_d  = 1'b1;
      end else begin
        sh_d = {sh_q[SH_W-2:0], rdat};
      end
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      word_q <= '0;
      chan_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      word_q <= word_d;
      chan_q <= chan_d;
      vld_q  <= vld_d;
    end
  end

  assign rx_valid = vld_q;
  assign rx_chan  = chan_q;
  assign rx_word  = word_q;

  // R4: a delivered word is a single-cycle pulse
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7: delivery only follows the final bit of an enabled receive slot
  p_valid_from_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(data_tick && rx_on && last_bit));

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer #(
  parameter int MAX_CH = 32,
  parameter int WORD_W = 16,
  parameter int DLY_W  = 2,
  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic [CH_W-1:0]   cfg_chan_last,
  input  logic [DLY_W-1:0]  cfg_delay,
  input  logic [MAX_CH-1:0] cfg_tx_mask,
  input  logic [MAX_CH-1:0] cfg_rx_mask,
  output logic [CH_W-1:0]   tx_chan,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tdat,
  output logic              toe,
  input  logic              rdat,
  output logic              rx_valid,
  output logic [CH_W-1:0]   rx_chan,
  output logic [WORD_W-1:0] rx_word,
  output logic              frame_err
);

  logic            data_tick;
  logic            first_bit;
  logic            last_bit;
  logic            tx_on;
  logic            rx_on;
  logic [CH_W-1:0] slot;

  tdm_seq #(
    .MAX_CH (MAX_CH),
    .WORD_W (WORD_W),
    .DLY_W  (DLY_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .bit_en        (bit_en),
    .fsync         (fsync),
    .cfg_chan_last (cfg_chan_last),
    .cfg_delay     (cfg_delay),
    .cfg_tx_mask   (cfg_tx_mask),
    .cfg_rx_mask   (cfg_rx_mask),
    .data_tick     (data_tick),
    .first_bit     (first_bit),
    .last_bit      (last_bit),
    .tx_on         (tx_on),
    .rx_on         (rx_on),
    .slot          (slot),
    .frame_err     (frame_err)
  );

  tdm_tx #(
    .WORD_W (WORD_W)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .bit_en    (bit_en),
    .data_tick (data_tick),
    .first_bit (first_bit),
    .tx_on     (tx_on),
    .tx_word   (tx_word),
    .tdat      (tdat),
    .toe       (toe)
  );

  tdm_rx #(
    .WORD_W (WORD_W),
    .CH_W   (CH_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_tick (data_tick),
    .last_bit  (last_bit),
    .rx_on     (rx_on),
    .slot      (slot),
    .rdat      (rdat),
    .rx_valid  (rx_valid),
    .rx_chan   (rx_chan),
    .rx_word   (rx_word)
  );

  assign tx_chan = slot;

endmodule

// File: tb/tb_tdm_framer.sv
module tb_tdm_framer;

  localparam int W   = 16;
  localparam int NCH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        bit_en = 1'b0;
  logic        fsync = 1'b0;
  logic        rdat = 1'b0;
  logic [4:0]  cfg_chan_last = '0;
  logic [1:0]  cfg_delay = '0;
  logic [31:0] cfg_tx_mask = '0;
  logic [31:0] cfg_rx_mask = '0;
  logic [4:0]  tx_chan;
  logic [15:0] tx_word;
  logic        tdat, toe, rx_valid, frame_err;
  logic [4:0]  rx_chan;
  logic [15:0] rx_word;

  logic [15:0] tx_mem [NCH];
  logic [15:0] rx_pat [NCH];
  logic [15:0] rx_got [NCH];

  int total = 0, bad = 0, gap = 0, rx_cnt = 0, err_cnt = 0, first_dist = -1;
  bit chk_on = 1'b0, done = 1'b0, toe_prev = 1'b0, first_pend = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  assign tx_word = tx_mem[tx_chan];

  tdm_framer dut (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_en(bit_en), .fsync(fsync),
    .cfg_chan_last(cfg_chan_last), .cfg_delay(cfg_delay),
    .cfg_tx_mask(cfg_tx_mask), .cfg_rx_mask(cfg_rx_mask),
    .tx_chan(tx_chan), .tx_word(tx_word), .tdat(tdat), .toe(toe),
    .rdat(rdat), .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_word(rx_word),
    .frame_err(frame_err)
  );

  // ---------------- reference model: ticks counted since the sync ----------
  bit          m_busy = 1'b0;
  int          m_pos = 0, m_dly = 0, m_n = 1, since_sync = 0;
  logic [31:0] m_txm = '0, m_rxm = '0;
  logic [15:0] m_acc = '0, e_rw = '0;
  logic [4:0]  e_rc = '0;
  logic        e_toe = 1'b0, e_tdat = 1'b0, e_rv = 1'b0, e_err = 1'b0;

  always @(posedge clk) begin : model
    int j, s, b;
    bit dat, lastb, was;
    if (!rst_n) begin
      m_busy = 1'b0; e_toe = 1'b0; e_tdat = 1'b0; e_rv = 1'b0; e_err = 1'b0;
    end else begin
      e_rv = 1'b0;
      e_err = 1'b0;
      if (!en) begin
        m_busy = 1'b0; e_toe = 1'b0; e_tdat = 1'b0;
      end else if (bit_en) begin
        dat = 1'b0; lastb = 1'b0; was = m_busy; j = 0; s = 0; b = 0;
        since_sync++;
        if (m_busy) begin
          j = m_pos - m_dly;
          m_pos++;
          if (j >= 0) begin
            dat = 1'b1; s = j / W; b = j % W; lastb = (j == W * m_n - 1);
          end
        end
        if (dat) begin
          if (m_txm[s]) begin e_toe = 1'b1; e_tdat = tx_mem[s][15-b]; end
          else          begin e_toe = 1'b0; e_tdat = 1'b0; end
          if (m_rxm[s]) begin
            m_acc = {m_acc[14:0], rdat};
            if (b == W - 1) begin e_rv = 1'b1; e_rw = m_acc; e_rc = 5'(s); end
          end
          if (lastb) m_busy = 1'b0;
        end else begin
          e_toe = 1'b0; e_tdat = 1'b0;
        end
        if (fsync) begin
          e_err = was && !lastb;
          m_busy = 1'b1; m_pos = 0; m_dly = int'(cfg_delay);
          m_n = int'(cfg_chan_last) + 1; m_txm = cfg_tx_mask; m_rxm = cfg_rx_mask;
          since_sync = 0; first_pend = 1'b1;
        end
      end
    end
  end

  // ---------------- per-clock comparison, away from the active edge --------
  always @(negedge clk) begin
    if (chk_on) begin
      total++;
      if (toe !== e_toe || tdat !== e_tdat || rx_valid !== e_rv || frame_err !== e_err ||
          (e_rv && (rx_word !== e_rw || rx_chan !== e_rc))) begin
        bad++;
        $display("FAIL %s per-clock: actual toe=%b tdat=%b rv=%b word=%h chan=%0d err=%b expected toe=%b tdat=%b rv=%b word=%h chan=%0d err=%b",
                 cur_req, toe, tdat, rx_valid, rx_word, rx_chan, frame_err,
                 e_toe, e_tdat, e_rv, e_rw, e_rc, e_err);
      end
      if (rx_valid) begin rx_got[rx_chan] = rx_word; rx_cnt++; end
      if (frame_err) err_cnt++;
      if (toe && !toe_prev && first_pend) begin first_dist = since_sync; first_pend = 1'b0; end
      toe_prev = toe;
    end
  end

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic fs, input logic rd);
    @(negedge clk);
    bit_en = 1'b1; fsync = fs; rdat = rd;
    repeat (gap) begin @(negedge clk); bit_en = 1'b0; fsync = 1'b0; end
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bit_en = 1'b0; fsync = 1'b0; rdat = 1'b0; end
  endtask

  task automatic clear_rx();
    rx_cnt = 0;
    first_dist = -1;
    for (int i = 0; i < NCH; i++) rx_got[i] = 16'hDEAD;
  endtask

  // gap ticks then slot bits; stops early after 'abort' data ticks when >= 0
  task automatic run_body(input int dly, input int last, input int abort, input bit sync_last, input bit swap);
    int n;
    bit first;
    n = 0;
    first = 1'b1;
    for (int g = 0; g < dly; g++) begin
      tick(1'b0, 1'b0);
      if (first && swap) begin cfg_chan_last = '0; cfg_delay = 2'd3; cfg_tx_mask = '0; cfg_rx_mask = '0; end
      first = 1'b0;
    end
    for (int s = 0; s <= last; s++) begin
      for (int b = W - 1; b >= 0; b--) begin
        if (abort >= 0 && n == abort) return;
        tick((sync_last && s == last && b == 0) ? 1'b1 : 1'b0, rx_pat[s][b]);
        if (first && swap) begin cfg_chan_last = '0; cfg_delay = 2'd3; cfg_tx_mask = '0; cfg_rx_mask = '0; end
        first = 1'b0;
        n++;
      end
    end
  endtask

  task automatic run_frame(input int dly, input int last, input logic [31:0] txm, input logic [31:0] rxm,
                           input int abort, input bit sync_last, input bit swap);
    @(negedge clk);
    cfg_delay = 2'(dly); cfg_chan_last = 5'(last); cfg_tx_mask = txm; cfg_rx_mask = rxm;
    bit_en = 1'b1; fsync = 1'b1; rdat = 1'b0;
    repeat (gap) begin @(negedge clk); bit_en = 1'b0; fsync = 1'b0; end
    run_body(dly, last, abort, sync_last, swap);
  endtask

  function automatic logic [31:0] span(input int last);
    return (last >= 31) ? 32'hFFFF_FFFF : ((32'h1 << (last + 1)) - 32'h1);
  endfunction

  // full frame plus the directed checks that follow from the requirements
  task automatic frame_test(input string req, input int dly, input int last,
                            input logic [31:0] txm, input logic [31:0] rxm, input bit swap);
    int e0;
    cur_req = req;
    clear_rx();
    e0 = err_cnt;
    run_frame(dly, last, txm, rxm, -1, 1'b0, swap);
    idle(6);
    if (txm[0]) chk(first_dist == dly + 1, "R2", "ticks from sync to first data bit", first_dist, dly + 1);
    chk(rx_cnt == $countones(rxm & span(last)), "R5", "words received in frame", rx_cnt, $countones(rxm & span(last)));
    for (int s = 0; s <= last; s++)
      if (rxm[s]) chk(rx_got[s] == rx_pat[s], "R4", $sformatf("slot %0d word", s), rx_got[s], rx_pat[s]);
    chk(err_cnt == e0, "R8", "no error on a clean frame", err_cnt - e0, 0);
  endtask

  initial begin : stim
    int e0;
    for (int s = 0; s < NCH; s++) begin
      tx_mem[s] = 16'hC3A5 ^ 16'(s * 16'h0911);
      rx_pat[s] = 16'h5A3C ^ 16'(s * 16'h1357);
    end
    tx_mem[0] = 16'h8001;
    rx_pat[1] = 16'h8000;
    rx_pat[2] = 16'hA5A5;
    clear_rx();

    // R1: reset state
    repeat (2) @(negedge clk);
    chk(toe == 1'b0 && tdat == 1'b0, "R1", "tx pin idle in reset", {toe, tdat}, 0);
    chk(rx_valid == 1'b0 && frame_err == 1'b0, "R1", "no pulses in reset", {rx_valid, frame_err}, 0);
    chk(tx_chan == 5'd0, "R1", "tx_chan in reset", tx_chan, 0);
    chk_on = 1'b1;
    rst_n = 1'b1;
    idle(3);
    en = 1'b1;

    // R2/R3/R4: first frame after enable, gap 0, back-to-back ticks
    gap = 0;
    frame_test("R2", 0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    // R11: idle clocks between ticks
    gap = 1;
    frame_test("R11", 1, 4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    gap = 2;
    frame_test("R3", 2, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    // R5: full 32-slot frame and single-slot frame
    gap = 0;
    frame_test("R5", 3, 31, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    chk(rx_got[31] == rx_pat[31], "R5", "final slot 31 kept", rx_got[31], rx_pat[31]);
    frame_test("R5", 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    // R6/R7: slot masks
    frame_test("R6", 2, 15, 32'hAAAA_5555, 32'h0F0F_3C3C, 1'b0);
    chk(rx_got[0] == 16'hDEAD, "R7", "disabled rx slot 0 not delivered", rx_got[0], 16'hDEAD);
    // R9: configuration changed right after the sync tick
    frame_test("R9", 1, 7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);

    // R8: early sync restarts the frame and flags an error
    cur_req = "R8";
    clear_rx();
    e0 = err_cnt;
    run_frame(0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 40, 1'b0, 1'b0);
    run_frame(0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, 1'b0, 1'b0);
    idle(6);
    chk(err_cnt == e0 + 1, "R8", "one error for early sync", err_cnt - e0, 1);
    chk(rx_cnt == 6, "R8", "words from cut and restarted frame", rx_cnt, 6);
    chk(rx_got[3] == rx_pat[3], "R8", "restarted frame slot 3", rx_got[3], rx_pat[3]);

    // R8: sync on the final bit tick is a clean back-to-back frame
    clear_rx();
    e0 = err_cnt;
    run_frame(1, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, -1, 1'b1, 1'b0);
    run_body(1, 2, -1, 1'b0, 1'b0);
    idle(6);
    chk(err_cnt == e0, "R8", "no error for sync on final bit", err_cnt - e0, 0);
    chk(rx_cnt == 6, "R8", "both frames fully received", rx_cnt, 6);
    chk(rx_got[2] == rx_pat[2], "R8", "final word kept", rx_got[2], rx_pat[2]);

    // R10: disable mid-frame, syncs ignored while disabled
    cur_req = "R10";
    run_frame(0, 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 20, 1'b0, 1'b0);
    @(negedge clk);
    bit_en = 1'b0; fsync = 1'b0;
    en = 1'b0;
    idle(1);
    chk(toe == 1'b0 && tdat == 1'b0, "R10", "pin quiet after disable", {toe, tdat}, 0);
    clear_rx();
    e0 = err_cnt;
    tick(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) tick(1'b0, 1'(i % 3));
    tick(1'b1, 1'b1);
    idle(4);
    chk(rx_cnt == 0, "R10", "no capture while disabled", rx_cnt, 0);
    chk(err_cnt == e0, "R10", "no error while disabled", err_cnt - e0, 0);
    chk(toe == 1'b0, "R10", "toe low while disabled", toe, 0);
    en = 1'b1;
    idle(2);
    frame_test("R2", 1, 5, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);

    // R5: nothing after the frame ends
    cur_req = "R5";
    clear_rx();
    for (int i = 0; i < 20; i++) tick(1'b0, 1'b1);
    idle(3);
    chk(rx_cnt == 0 && toe == 1'b0, "R5", "silence after frame", {rx_cnt, toe}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog all requirements: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule